// File: doc/BRIEF.md
# Latched Multiplexer Channel Controller

This block is the digital control side of a two-bank analog switch array. A host bus presents a channel address and an enable bit. A write strobe and an active-low clear strobe govern a set of held bits. While the strobe is low the held bits follow the bus. They are frozen when the strobe rises and stay unchanged while the strobe remains high. The held value is decoded into a one-hot switch-on vector covering bank A and bank B, four channels each by default.

In single-ended mode the top address bit picks the bank and the lower bits pick the channel. In paired mode the top bit is ignored and the same channel closes in both banks, which routes a differential pair. A readback control turns the address and enable pins around so that they drive the held contents. The bus is modelled as separate input, output and output-enable signals.

Every input is sampled on one system clock. Setup, hold, strobe low width and clear-to-write recovery are counted in clock cycles. A strobe edge that breaks any of these limits commits nothing, returns the held bits to the last committed value and raises a sticky error flag.

Top module: `chsel_mux_ctl`

## Requirements
- R1: A sample with `clr_n` low clears the held address and enable, turns every switch off and clears `timing_err`, all visible on the next cycle, whatever the other inputs are.
- R2: With `clr_n` high, `rdbk` low and `wstb` low, the held value becomes the sampled bus, so `sw_on`, `addr_out` and `en_out` follow the bus one cycle later.
- R3: While `wstb` stays high and no capture is pending, the held value and the switch selection do not change, whatever the bus does.
- R4: A held enable of 0 gives `sw_on` equal to zero for any address.
- R5: In single-ended mode (`pair_mode`=0) exactly one switch is on when enabled: bit index = addr[2]*4 + addr[1:0], with bits 0..3 being bank A channels 1..4 and bits 4..7 being bank B channels 1..4.
- R6: In paired mode (`pair_mode`=1) addr[2] is ignored and bits addr[1:0] and 4+addr[1:0] are both on when enabled.
- R7: `bus_oe` equals `rdbk` delayed by one cycle, and `addr_out`/`en_out` always carry the held contents.
- R8: A change of `pair_mode` changes only the decode. The held address and enable read back unchanged.
- R9: A rising `wstb` is accepted only if three things hold. The bus must have been unchanged for at least SETUP_CYC samples before the edge sample. `wstb` must have been low for at least PW_CYC samples before it. At least REC_CYC samples with `clr_n` high must precede it. Otherwise the held value reverts to the last committed one and `timing_err` is set.
- R10: After an accepted edge the bus must equal the captured value on each of the next HOLD_CYC samples (samples with `rdbk` high are exempt). A mismatch reverts the held value to the previous committed one and sets `timing_err`. A clean window commits the captured value.
- R11: An accepted edge freezes the value present on the edge sample; bus changes in later high-strobe cycles are not taken.
- R12: While `rdbk` is high and no capture is pending, bus input values never update the held value and strobe edges are not acted on.
- R13: `timing_err` stays set until a reset or a `clr_n` low sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | Address bus, input side |
| en_in | input | 1 | Enable bus bit, input side |
| addr_out | output | ADDR_W | Held address driven for readback |
| en_out | output | 1 | Held enable driven for readback |
| bus_oe | output | 1 | Output enable for the address/enable pins |
| wstb | input | 1 | Write strobe: low = transparent, rising = capture, high = hold |
| clr_n | input | 1 | Active-low clear of the held bits |
| rdbk | input | 1 | Readback request |
| pair_mode | input | 1 | 0 = single-ended, 1 = paired decode |
| sw_on | output | 2*CH | Switch-on vector, bank A low half, bank B high half |
| timing_err | output | 1 | Sticky strobe timing violation flag |

## Verification
The hardest situation to reach is a capture that is first accepted and then withdrawn: a clean edge is followed by a bus change inside the hold window. Here the held value must fall back to a commit that is older than the transparent value just shown. The stimulus builds this on purpose. It first commits one address, then shows a second one transparently, raises the strobe cleanly and changes the bus on the very next sample. Recovery and width violations are likewise staged by placing the rising edge just after a clear or a one-cycle low pulse. A randomized stretch then mixes all controls against the cycle-level reference model.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_PAIR   = 1'b1
  } pair_mode_e;

  // Results of the strobe-edge window checks
  typedef struct packed {
    logic setup_ok;
    logic width_ok;
    logic recov_ok;
  } win_chk_t;

endpackage

// File: rtl/chsel_window_mon.sv
module chsel_window_mon
  import chsel_pkg::*;
#(
  parameter int BUS_W    = 4,
  parameter int SETUP_CYC = 2,
  parameter int PW_CYC    = 2,
  parameter int REC_CYC   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             strobe,
  input  logic [BUS_W-1:0] bus_in,
  output logic             rise,
  output win_chk_t         chk
);

  localparam int LIM_A   = (SETUP_CYC > PW_CYC) ? SETUP_CYC : PW_CYC;
  localparam int LIM_MAX = (LIM_A > REC_CYC) ? LIM_A : REC_CYC;
  localparam int CNT_W   = $clog2(LIM_MAX + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic             prev_stb_q;
  logic [BUS_W-1:0] prev_bus_q;
  logic [CNT_W-1:0] run_q, run_now;
  logic [CNT_W-1:0] low_q;
  logic [CNT_W-1:0] rec_q;

  assign rise = strobe & ~prev_stb_q;

  always_comb begin
    if (bus_in != prev_bus_q)  run_now = '0;
    else if (run_q == CNT_TOP) run_now = run_q;
    else                       run_now = run_q + 1'b1;
  end

  assign chk.setup_ok = (run_now >= CNT_W'(SETUP_CYC));
  assign chk.width_ok = (low_q   >= CNT_W'(PW_CYC));
  assign chk.recov_ok = (rec_q   >= CNT_W'(REC_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_stb_q <= 1'b1;
      prev_bus_q <= '0;
      run_q      <= '0;
      low_q      <= '0;
      rec_q      <= CNT_W'(REC_CYC);
    end else begin
      prev_stb_q <= strobe;
      prev_bus_q <= bus_in;
      run_q      <= run_now;
      if (strobe)               low_q <= '0;
      else if (low_q != CNT_TOP) low_q <= low_q + 1'b1;
      if (!clr_n)               rec_q <= '0;
      else if (rec_q != CNT_TOP) rec_q <= rec_q + 1'b1;
    end
  end

  // R9
  recov_after_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> !chk.recov_ok);

endmodule

// File: rtl/chsel_latch_core.sv
module chsel_latch_core
  import chsel_pkg::*;
#(
  parameter int BUS_W    = 4,
  parameter int HOLD_CYC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             rdbk,
  input  logic             strobe,
  input  logic             rise,
  input  win_chk_t         chk,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] lat_d,
  output logic [BUS_W-1:0] lat_q,
  output logic             err_q
);

  localparam int PC_W      = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam int HOLD_LAST = (HOLD_CYC > 0) ? HOLD_CYC - 1 : 0;

  logic [BUS_W-1:0] hold_q, hold_d;
  logic             pend_q, pend_d;
  logic [PC_W-1:0]  pcnt_q, pcnt_d;
  logic             err_d;
  logic             edge_good;

  assign edge_good = chk.setup_ok & chk.width_ok & chk.recov_ok;

  always_comb begin
    lat_d  = lat_q;
    hold_d = hold_q;
    pend_d = pend_q;
    pcnt_d = pcnt_q;
    err_d  = err_q;
    if (!clr_n) begin
      lat_d  = '0;
      hold_d = '0;
      pend_d = 1'b0;
      pcnt_d = '0;
      err_d  = 1'b0;
    end else if (pend_q) begin
      if (!rdbk && (bus_in != lat_q)) begin
        lat_d  = hold_q;
        pend_d = 1'b0;
        pcnt_d = '0;
        err_d  = 1'b1;
      end else if (pcnt_q == PC_W'(HOLD_LAST)) begin
        hold_d = lat_q;
        pend_d = 1'b0;
        pcnt_d = '0;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end else if (rdbk) begin
      lat_d = lat_q;
    end else if (rise) begin
      if (edge_good) begin
        lat_d = bus_in;
        if (HOLD_CYC == 0) begin
          hold_d = bus_in;
        end else begin
          pend_d = 1'b1;
          pcnt_d = '0;
        end
      end else begin
        lat_d = hold_q;
        err_d = 1'b1;
      end
    end else if (!strobe) begin
      lat_d = bus_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
      pcnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      lat_q  <= lat_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
      pcnt_q <= pcnt_d;
      err_q  <= err_d;
    end
  end

  // R1
  clear_wipes_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (lat_q == '0) && !err_q);

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && clr_n) |=> err_q);

  // R3
  hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe && !rise && !pend_q) |=> $stable(lat_q));

  // R12
  rdbk_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && rdbk && !pend_q) |=> $stable(lat_q));

endmodule

// File: rtl/chsel_decode.sv
module chsel_decode
  import chsel_pkg::*;
#(
  parameter int CH    = 4,
  parameter int LOW_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [LOW_W:0]  addr,
  input  logic            pair_mode,
  output logic [2*CH-1:0] sw_q
);

  logic [2*CH-1:0] dec;
  logic            pair;

  assign pair = (pair_mode_e'(pair_mode) == MODE_PAIR);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar c = 0; c < CH; c++) begin : g_chan
      assign dec[b*CH + c] = en
                           && (addr[LOW_W-1:0] == LOW_W'(c))
                           && (pair || (addr[LOW_W] == b[0]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sw_q <= '0;
    else     sw_q <= dec;
  end

  // R5
  single_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    !pair_mode |=> $onehot0(sw_q));

  // R4
  disabled_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sw_q == '0));

  // R6
  pair_count_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_mode && en) |=> ($countones(sw_q) == 2));

endmodule

// File: rtl/chsel_mux_ctl.sv
module chsel_mux_ctl
  import chsel_pkg::*;
#(
  parameter int CH        = 4,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int PW_CYC    = 2,
  parameter int REC_CYC   = 3,
  localparam int LOW_W    = (CH < 2) ? 1 : $clog2(CH),
  localparam int ADDR_W   = LOW_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              en_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              en_out,
  output logic              bus_oe,
  input  logic              wstb,
  input  logic              clr_n,
  input  logic              rdbk,
  input  logic              pair_mode,
  output logic [2*CH-1:0]   sw_on,
  output logic              timing_err
);

  localparam int BUS_W = ADDR_W + 1;

  logic [BUS_W-1:0] bus_vec;
  logic [BUS_W-1:0] lat_d, lat_q;
  logic             rise;
  win_chk_t         chk;
  logic             oe_q;

  assign bus_vec = {en_in, addr_in};

  chsel_window_mon #(
    .BUS_W(BUS_W), .SETUP_CYC(SETUP_CYC), .PW_CYC(PW_CYC), .REC_CYC(REC_CYC)
  ) i_win (
    .clk(clk), .rst(rst), .clr_n(clr_n), .strobe(wstb),
    .bus_in(bus_vec), .rise(rise), .chk(chk)
  );

  chsel_latch_core #(
    .BUS_W(BUS_W), .HOLD_CYC(HOLD_CYC)
  ) i_core (
    .clk(clk), .rst(rst), .clr_n(clr_n), .rdbk(rdbk), .strobe(wstb),
    .rise(rise), .chk(chk), .bus_in(bus_vec),
    .lat_d(lat_d), .lat_q(lat_q), .err_q(timing_err)
  );

  chsel_decode #(
    .CH(CH), .LOW_W(LOW_W)
  ) i_dec (
    .clk(clk), .rst(rst), .en(lat_d[BUS_W-1]), .addr(lat_d[ADDR_W-1:0]),
    .pair_mode(pair_mode), .sw_q(sw_on)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= rdbk;
  end

  assign bus_oe   = oe_q;
  assign addr_out = lat_q[ADDR_W-1:0];
  assign en_out   = lat_q[BUS_W-1];

  // R7
  oe_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rdbk |=> bus_oe);

  // R1
  clear_off_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (sw_on == '0));

  // R8
  mode_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && wstb && rdbk && $past(wstb)) |=> $stable({en_out, addr_out}));

endmodule

// File: tb/test_chsel_mux_ctl.sv
module test_chsel_mux_ctl;

  localparam int SETUP = 2, HOLD = 1, PW = 2, REC = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr_in = '0;
  logic       en_in = 1'b0;
  logic       wstb = 1'b1, clr_n = 1'b1, rdbk = 1'b0, pair_mode = 1'b0;
  logic [2:0] addr_out;
  logic       en_out, bus_oe, timing_err;
  logic [7:0] sw_on;

  chsel_mux_ctl #(.CH(4), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD),
                  .PW_CYC(PW), .REC_CYC(REC)) i_chsel_mux_ctl (
    .clk(clk), .rst(rst), .addr_in(addr_in), .en_in(en_in),
    .addr_out(addr_out), .en_out(en_out), .bus_oe(bus_oe),
    .wstb(wstb), .clr_n(clr_n), .rdbk(rdbk), .pair_mode(pair_mode),
    .sw_on(sw_on), .timing_err(timing_err)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit started = 0;

  // reference model state
  int m_addr, m_en, h_addr, h_en, m_pend, m_pcnt, m_err;
  int m_prev_s, m_prev_bus, m_run, m_low, m_rec, m_oe;
  logic [7:0] m_sw;

  function automatic logic [7:0] decode(int a, int e, int pm);
    logic [7:0] v = '0;
    if (e != 0) begin
      if (pm != 0) begin v[a % 4] = 1'b1; v[4 + a % 4] = 1'b1; end
      else v[a] = 1'b1;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    int bus, run_now, rise;
    started = 1;
    bus = {en_in, addr_in};
    if (rst) begin
      m_addr = 0; m_en = 0; h_addr = 0; h_en = 0; m_pend = 0; m_pcnt = 0;
      m_err = 0; m_prev_s = 1; m_prev_bus = 0; m_run = 0; m_low = 0;
      m_rec = REC; m_oe = 0; m_sw = '0;
    end else begin
      rise = (wstb && m_prev_s == 0) ? 1 : 0;
      run_now = (bus == m_prev_bus) ? ((m_run < 1000) ? m_run + 1 : m_run) : 0;
      if (!clr_n) begin
        m_addr = 0; m_en = 0; h_addr = 0; h_en = 0; m_pend = 0; m_pcnt = 0; m_err = 0;
      end else if (m_pend != 0) begin
        if (!rdbk && (int'(addr_in) != m_addr || int'(en_in) != m_en)) begin
          m_addr = h_addr; m_en = h_en; m_pend = 0; m_pcnt = 0; m_err = 1;
        end else if (m_pcnt == HOLD - 1) begin
          h_addr = m_addr; h_en = m_en; m_pend = 0; m_pcnt = 0;
        end else m_pcnt++;
      end else if (rdbk) begin
        // bus ignored
      end else if (rise != 0) begin
        if (run_now >= SETUP && m_low >= PW && m_rec >= REC) begin
          m_addr = addr_in; m_en = en_in; m_pend = 1; m_pcnt = 0;
        end else begin
          m_addr = h_addr; m_en = h_en; m_err = 1;
        end
      end else if (!wstb) begin
        m_addr = addr_in; m_en = en_in;
      end
      m_prev_s = wstb; m_prev_bus = bus; m_run = run_now;
      m_low = wstb ? 0 : ((m_low < 1000) ? m_low + 1 : m_low);
      m_rec = !clr_n ? 0 : ((m_rec < 1000) ? m_rec + 1 : m_rec);
      m_oe = rdbk;
      m_sw = decode(m_addr, m_en, pair_mode);
    end
  end

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (started) begin
      chk(tag, "sw_on", sw_on, m_sw);
      chk(tag, "addr_out", addr_out, m_addr);
      chk(tag, "en_out", en_out, m_en);
      chk(tag, "bus_oe", bus_oe, m_oe);
      chk(tag, "timing_err", timing_err, m_err);
    end
  end

  task automatic put(int a, int e, int s, int c, int r, int pm);
    @(negedge clk);
    #1;
    addr_in = a[2:0]; en_in = e[0]; wstb = s[0]; clr_n = c[0];
    rdbk = r[0]; pair_mode = pm[0];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // clean write of (a,e): transparent for 3 cycles, rise, hold
  task automatic write_ok(int a, int e, int pm);
    for (int i = 0; i < 3; i++) put(a, e, 0, 1, 0, pm);
    put(a, e, 1, 1, 0, pm);
    put(a, e, 1, 1, 0, pm);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    tag = "R1";
    idle(3);
    @(negedge clk); #1 rst = 1'b0;
    @(negedge clk); #2;
    chk("R1", "reset sw_on", sw_on, 0);
    chk("R1", "reset err", timing_err, 0);

    tag = "R2";
    for (int a = 0; a < 8; a++) put(a, 1, 0, 1, 0, 0);
    @(negedge clk); #2;
    chk("R2", "transparent follow", addr_out, 7);
    tag = "R5";
    for (int a = 0; a < 8; a++) begin
      put(a, 1, 0, 1, 0, 0);
      @(negedge clk); #2;
      chk("R5", "single decode", sw_on, 1 << a);
    end

    tag = "R11";
    write_ok(5, 1, 0);
    put(2, 1, 1, 1, 0, 0);
    put(6, 0, 1, 1, 0, 0);
    @(negedge clk); #2;
    chk("R11", "frozen value", addr_out, 5);
    tag = "R3";
    chk("R3", "held switch", sw_on, 8'h20);

    tag = "R6";
    put(6, 0, 1, 1, 0, 1);
    @(negedge clk); #2;
    chk("R6", "pair decode", sw_on, 8'h22);
    tag = "R8";
    put(0, 1, 1, 1, 0, 0);
    @(negedge clk); #2;
    chk("R8", "mode change keeps latch", addr_out, 5);
    for (int a = 0; a < 8; a++) begin
      tag = "R6";
      write_ok(a, 1, 1);
      @(negedge clk); #2;
      chk("R6", "pair decode sweep", sw_on, (1 << (a % 4)) | (16 << (a % 4)));
    end

    tag = "R7";
    put(3, 0, 1, 1, 1, 0);
    tag = "R12";
    put(1, 1, 0, 1, 1, 0);
    put(2, 1, 0, 1, 1, 0);
    put(2, 1, 1, 1, 1, 0);
    @(negedge clk); #2;
    chk("R7", "oe on", bus_oe, 1);
    chk("R12", "readback ignores bus", addr_out, 7);
    put(2, 1, 1, 1, 0, 0);
    idle(2);

    tag = "R4";
    for (int a = 0; a < 8; a++) put(a, 0, 0, 1, 0, a & 1);
    @(negedge clk); #2;
    chk("R4", "disabled", sw_on, 0);

    tag = "R9";
    write_ok(4, 1, 0);
    put(1, 1, 0, 1, 0, 0);
    put(1, 1, 0, 1, 0, 0);
    put(3, 1, 1, 1, 0, 0);
    @(negedge clk); #2;
    chk("R9", "setup violation err", timing_err, 1);
    chk("R9", "setup violation revert", addr_out, 4);
    tag = "R13";
    idle(4);
    chk("R13", "sticky", timing_err, 1);
    tag = "R1";
    put(3, 1, 1, 0, 1, 1);
    put(3, 1, 1, 1, 0, 0);
    @(negedge clk); #2;
    chk("R1", "clear", sw_on, 0);
    chk("R13", "cleared by clr", timing_err, 0);

    tag = "R9";
    for (int i = 0; i < 4; i++) put(2, 1, 1, 1, 0, 0);
    put(2, 1, 0, 1, 0, 0);
    put(2, 1, 1, 1, 0, 0);
    @(negedge clk); #2;
    chk("R9", "width violation", timing_err, 1);
    put(2, 1, 0, 0, 0, 0);
    put(2, 1, 0, 1, 0, 0);
    put(2, 1, 1, 1, 0, 0);
    @(negedge clk); #2;
    chk("R9", "recovery violation", timing_err, 1);
    put(2, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) put(2, 1, 0, 1, 0, 0);
    put(2, 1, 1, 1, 0, 0);
    idle(2);
    chk("R9", "legal after recovery", timing_err, 0);

    tag = "R10";
    write_ok(6, 1, 0);
    for (int i = 0; i < 3; i++) put(1, 1, 0, 1, 0, 0);
    put(1, 1, 1, 1, 0, 0);
    put(0, 1, 1, 1, 0, 0);
    @(negedge clk); #2;
    chk("R10", "hold violation revert", addr_out, 6);
    chk("R10", "hold violation err", timing_err, 1);

    tag = "R13";
    for (int i = 0; i < 600; i++) begin
      int v = $urandom;
      put(v & 7, (v >> 3) & 1, ((v >> 4) & 3) != 0, ((v >> 6) & 31) != 0,
          ((v >> 11) & 7) == 0, (v >> 14) & 1);
    end
    idle(2);
    summary();
    $finish;
  end

endmodule